// File: doc/BRIEF.md
# Bitonic Token Counting Network

This block spreads single-cycle token pulses from a set of input wires evenly over the same number of output wires. The number of wires, `WIDTH`, is a power of two. Tokens may arrive on any input, in any cycle and in any number. Once the network drains, the number of tokens seen on each output differs by at most one, and the lower-numbered outputs carry the extra tokens. If each output keeps a small local counter that starts at its own index and steps by `WIDTH`, the outputs together issue consecutive numbers without any shared counting element.

The network is built from two-input, two-output toggle elements. Each element sends successive tokens alternately to its low and high output. The elements are wired in the recursive bitonic merger pattern. Each layer of elements registers its outputs, so every token leaves the network a fixed number of cycles after it enters.

A synchronous reset discards all tokens in flight and returns every toggle to its initial state.

Top module: `bitonic_count_net`

## Requirements
- R1: Each toggle element sends a lone token to its low output if the previous lone token went to its high output, and to its high output otherwise; the first lone token after reset goes to the low output.
- R2: No token is created or lost: once input stops and the network drains, the total count of output pulses equals the total count of input pulses.
- R3: When both inputs of an element carry a token in the same cycle, one token leaves on each output and the element's toggle keeps its value.
- R4: The latency is exactly L = log2(WIDTH)·(log2(WIDTH)+1)/2 cycles (6 for WIDTH = 8); in every cycle the number of pulses on `tokOut` equals the number of pulses on `tokIn` L cycles earlier.
- R5: A single token that enters a drained network after m tokens have passed since reset leaves on output m mod WIDTH; tokens fed one at a time therefore leave on outputs 0, 1, 2, … in turn.
- R6: After m tokens and a full drain, output i has emitted exactly ceil((m − i)/WIDTH) tokens, so for i < j the counts satisfy 0 ≤ count_i − count_j ≤ 1.
- R7: With `rst` high at a clock edge, all output pulses are zero after that edge, tokens in flight are discarded, and the next lone token leaves on output 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| tokIn | input | WIDTH | One bit per input wire; a 1 is a token in this cycle |
| tokOut | output | WIDTH | One bit per output wire; a 1 is a token leaving in this cycle |

## Verification
A token driven on `tokIn` before edge k is captured by the first layer at edge k and appears on `tokOut` after edge k+L−1. The bench drives and samples at the falling edge, so a sample taken L falling edges after a drive shows that drive's tokens. The reference model keeps a ring of per-cycle input counts and the expected output index of every lone token issued into an empty network, and compares both on every cycle at exactly that offset. Per-output totals and step-property checks are taken only after L+2 idle cycles, when nothing can still be in flight.

// File: rtl/cnet_pkg.sv
package cnet_pkg;

  // Strobes from a toggle controller to the layer datapath.
  typedef struct packed {
    logic toLow;
    logic toHigh;
  } balRoute_t;

  // Stage index s (1-based) of global layer L: stage s holds s layers.
  function automatic int layerStage(input int L);
    int s;
    int acc;
    s = 1;
    acc = 0;
    while (L >= acc + s) begin
      acc += s;
      s++;
    end
    return s;
  endfunction

  // Step t (1-based) of global layer L inside its merger stage.
  function automatic int layerStep(input int L);
    int s;
    int acc;
    s = 1;
    acc = 0;
    while (L >= acc + s) begin
      acc += s;
      s++;
    end
    return L - acc + 1;
  endfunction

  // Position in the first merger layer taken by merger input p (merger size m).
  function automatic int mergePos(input int m, input int p);
    int pos;
    int size;
    int idx;
    int k;
    int q;
    bit upper;
    bit toA;
    pos = 0;
    size = m;
    idx = p;
    while (size > 2) begin
      k = size / 2;
      upper = (idx >= k);
      q = upper ? idx - k : idx;
      toA = upper ? (q % 2 == 1) : (q % 2 == 0);
      idx = (upper ? k / 2 : 0) + q / 2;
      if (!toA) pos += k;
      size = k;
    end
    return pos + idx;
  endfunction

  // Inverse of mergePos: which merger input feeds first-layer position r.
  function automatic int mergeSrc(input int m, input int r);
    int found;
    found = 0;
    for (int p = 0; p < m; p++) begin
      if (mergePos(m, p) == r) found = p;
    end
    return found;
  endfunction

  // Index in the previous layer's vector that drives input position pos of layer L.
  // Element j of a layer reads positions 2j (a) and 2j+1 (b), writes 2j (low) and 2j+1 (high).
  function automatic int srcFor(input int L, input int pos);
    int s;
    int t;
    int m;
    int base;
    int b;
    int i;
    s = layerStage(L);
    t = layerStep(L);
    if (t == 1) begin
      m = 1 << s;
      base = (pos / m) * m;
      return base + mergeSrc(m, pos - base);
    end
    b = 1 << t;
    base = (pos / b) * b;
    i = pos / 2 - base / 2;
    return base + i + (pos % 2) * (b / 2);
  endfunction

endpackage

// File: rtl/cnet_toggle_ctl.sv
module cnet_toggle_ctl
  import cnet_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tokA,
  input  logic      tokB,
  output balRoute_t route
);

  logic steerHigh;
  logic lone;
  logic pair;

  assign lone = tokA ^ tokB;
  assign pair = tokA & tokB;

  always_comb begin
    route.toLow  = pair | (lone & ~steerHigh);
    route.toHigh = pair | (lone & steerHigh);
  end

  always_ff @(posedge clk) begin
    if (rst) steerHigh <= 1'b0;
    else if (lone) steerHigh <= ~steerHigh;
  end

  AST_LONE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    (lone && $past(!rst) && $past(lone)) |-> (route.toLow == $past(route.toHigh))); // R1

  AST_ROUTE_BALANCED: assert property (@(posedge clk) disable iff (rst)
    $countones({route.toLow, route.toHigh}) == $countones({tokA, tokB})); // R2

  AST_PAIR_KEEPS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (pair && !$past(rst)) |=> (steerHigh == $past(steerHigh))); // R3

  AST_RESET_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && lone) |-> (route.toLow && !route.toHigh)); // R7

endmodule

// File: rtl/cnet_layer.sv
module cnet_layer
  import cnet_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int LAYER = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] prevVec,
  output logic [WIDTH-1:0] nextVec
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] inVec;
  balRoute_t        route [HALF];

  for (genvar pos = 0; pos < WIDTH; pos++) begin : g_wire
    localparam int SRC = srcFor(LAYER, pos);
    assign inVec[pos] = prevVec[SRC];
  end

  for (genvar j = 0; j < HALF; j++) begin : g_bal
    cnet_toggle_ctl u_ctl (
      .clk  (clk),
      .rst  (rst),
      .tokA (inVec[2*j]),
      .tokB (inVec[2*j+1]),
      .route(route[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nextVec <= '0;
    end else begin
      for (int j = 0; j < HALF; j++) begin
        nextVec[2*j]   <= route[j].toLow;
        nextVec[2*j+1] <= route[j].toHigh;
      end
    end
  end

  AST_LAYER_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(nextVec) == $past($countones(prevVec)))); // R4

  AST_LAYER_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (nextVec == '0)); // R7

endmodule

// File: rtl/bitonic_count_net.sv
module bitonic_count_net #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] tokIn,
  output logic [WIDTH-1:0] tokOut
);

  localparam int LOG_W      = $clog2(WIDTH);
  localparam int NUM_LAYERS = LOG_W * (LOG_W + 1) / 2;

  logic [WIDTH-1:0] stageVec [NUM_LAYERS+1];

  assign stageVec[0] = tokIn;

  for (genvar L = 0; L < NUM_LAYERS; L++) begin : g_layer
    cnet_layer #(
      .WIDTH(WIDTH),
      .LAYER(L)
    ) u_layer (
      .clk    (clk),
      .rst    (rst),
      .prevVec(stageVec[L]),
      .nextVec(stageVec[L+1])
    );
  end

  assign tokOut = stageVec[NUM_LAYERS];

endmodule

// File: tb/bitonic_count_net_tb_top.sv
module bitonic_count_net_tb_top;

  localparam int W   = 8;
  localparam int LAT = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] tokIn = '0;
  logic [W-1:0] tokOut;

  always #5 clk = ~clk;

  bitonic_count_net #(.WIDTH(W)) dut_i (
    .clk   (clk),
    .rst   (rst),
    .tokIn (tokIn),
    .tokOut(tokOut)
  );

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  int    histCnt [64];
  int    histIdx [64];
  int    outCnt [W];
  int    inTotal = 0;
  int    inFlight = 0;
  string seqTag = "R5";
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < 64; i++) begin
      histCnt[i] = 0;
      histIdx[i] = -1;
    end
    for (int i = 0; i < W; i++) outCnt[i] = 0;
    inTotal = 0;
    inFlight = 0;
    cyc = 0;
  endtask

  // Sample outputs due now, then drive the next input vector.
  task automatic tick(input logic [W-1:0] v);
    int expCnt;
    int expIdx;
    int nowCnt;
    int newIdx;
    @(negedge clk);
    expCnt = (cyc >= LAT) ? histCnt[(cyc - LAT) % 64] : 0;
    expIdx = (cyc >= LAT) ? histIdx[(cyc - LAT) % 64] : -1;
    nowCnt = $countones(tokOut);
    check(nowCnt == expCnt, "R4", "tokens leaving this cycle", nowCnt, expCnt);
    if (expIdx >= 0)
      check(tokOut == (W'(1) << expIdx), seqTag, "lone token output vector",
            int'(tokOut), int'(W'(1) << expIdx));
    for (int i = 0; i < W; i++) outCnt[i] += int'(tokOut[i]);
    inFlight -= nowCnt;
    newIdx = -1;
    if ($countones(v) == 1 && inFlight == 0) newIdx = inTotal % W;
    histCnt[cyc % 64] = $countones(v);
    histIdx[cyc % 64] = newIdx;
    inTotal += $countones(v);
    inFlight += $countones(v);
    tokIn = v;
    cyc++;
  endtask

  task automatic drain();
    for (int k = 0; k < LAT + 2; k++) tick('0);
  endtask

  task automatic stepCheck(input string tag);
    int sum;
    sum = 0;
    for (int i = 0; i < W; i++) begin
      check(outCnt[i] == (inTotal + W - 1 - i) / W, tag, "per-output count after drain",
            outCnt[i], (inTotal + W - 1 - i) / W);
      sum += outCnt[i];
    end
    check(sum == inTotal, "R2", "total out vs total in", sum, inTotal);
  endtask

  task automatic lone(input int wire_n);
    tick(W'(1) << (wire_n % W));
    for (int k = 0; k < LAT - 1; k++) tick('0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    tokIn = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    clearModel();
    check(tokOut == '0, "R7", "outputs after reset", int'(tokOut), 0);
  endtask

  initial begin
    clearModel();
    doReset();

    // Lone tokens on scattered inputs: round-robin order from output 0.
    seqTag = "R1/R5";
    for (int n = 0; n < 20; n++) lone((n * 3 + 1) % W);
    drain();
    stepCheck("R6");

    // Two tokens meeting at one element in the same cycle.
    seqTag = "R3/R5";
    tick(8'b0000_0011);
    drain();
    stepCheck("R3");
    for (int n = 0; n < 4; n++) lone(n + 5);
    drain();
    stepCheck("R6");

    // Random bursts of varying density.
    seqTag = "R5";
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 60; k++) begin
        logic [W-1:0] v;
        v = W'($urandom);
        if (b == 0) v = v & W'($urandom);
        if (b == 2) v = v | W'($urandom);
        tick(v);
      end
      drain();
      stepCheck("R6");
      for (int n = 0; n < 3; n++) lone(n * 5 + b);
      drain();
      stepCheck("R6");
    end

    // Full load: every wire every cycle.
    for (int k = 0; k < W + 3; k++) tick('1);
    drain();
    stepCheck("R6");

    // Reset with tokens in flight.
    tick('1);
    tick(8'b1010_0101);
    tick(8'b0000_1000);
    doReset();
    seqTag = "R7";
    lone(6);
    seqTag = "R5";
    for (int n = 0; n < 9; n++) lone(n * 7);
    drain();
    stepCheck("R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule